// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block is the hazard control of a five-stage in-order integer pipeline: fetch, decode, execute, memory, writeback. Each cycle it looks at which architectural registers the decode and execute instructions read. It compares them with the registers the older instructions in execute, memory and writeback will write. From those comparisons it chooses where each ALU operand comes from: the register file, the ALU result held in the memory stage, or the value about to be written back.

It also handles two cases that forwarding cannot resolve. If a load in execute feeds the instruction in decode, it freezes the program counter and the fetch/decode register for one cycle and puts a bubble into execute. When a branch resolved in execute redirects the fetch path, it turns the two wrong-path instructions behind it into NOPs. The unit is purely combinational. The datapath multiplexers and pipeline registers that use its outputs sit outside it.

Top module: `fwd_hazard_unit`

## Requirements
- R1: With no write-enabled producer matching any source and no redirect, both forward selects are 2'b00 (register file) and pc_hold, ifid_hold, ifid_flush and ex_bubble are all 0.
- R2: A source register of index 0 always selects 2'b00, even when a stage with write enable high names register 0 as its destination.
- R3: When the memory stage has write enable high, is not a load, and its destination equals an execute source, that operand's select is 2'b01.
- R4: When the writeback stage has write enable high and its destination equals an execute source, and the memory stage does not supply it, that operand's select is 2'b10.
- R5: When both the memory and writeback stages qualify for the same source, the memory stage (the younger producer) wins and the select is 2'b01.
- R6: A stage whose write enable is low never causes a forward or a stall, whatever its destination.
- R7: A load in the memory stage is never forwarded as 2'b01; that operand falls back to the writeback match (2'b10) or the register file (2'b00).
- R8: A write-enabled load in execute whose nonzero destination equals the decode rs1 or rs2 raises pc_hold, ifid_hold and ex_bubble together, with ifid_flush at 0.
- R9: A non-load instruction in execute never raises a stall, even when its destination matches a decode source.
- R10: A redirect (branch taken or mispredicted in execute) raises ifid_flush and ex_bubble and leaves pc_hold and ifid_hold at 0. The forward selects keep their normal values.
- R11: A redirect and a load-use condition in the same cycle give the redirect result: flush and bubble high, no hold.
- R12: The two operand selects are decided independently; the two operands may take different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination register of the writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| redirect | input | 1 | Branch in execute was taken or mispredicted |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 memory-stage ALU result, 10 writeback value |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| ifid_flush | output | 1 | Load a NOP into the fetch/decode register |
| ex_bubble | output | 1 | Load a NOP into the decode/execute register |

## Verification
The forwarding selects are tried with one producer matching, both producers matching the same source, and the two operands matching different producers. These patterns separate a missing comparison from a wrong priority and from crossed operands. The same matches are repeated with write enable low, with register 0, and with a load sitting in the memory stage, to show which qualifiers the comparisons actually honour. The stall and flush controls are tried with a load feeding either decode source, with a non-load producer and with a redirect alone and combined with a load-use. This tells the interlock apart from forwarding and confirms the flush wins. A sweep over every register index with both producers enabled checks the register-0 rule and the priority across the whole index range.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// One comparison of a consumer source against one producer stage.
module hz_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              dst_we,
  input  logic              dst_ok,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = dst_we && dst_ok && (src != ZERO_REG) && (src == dst);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
// Priority pick for one operand: the younger producer wins.
module hz_fwd_pick (
  input  logic       hit_mem,
  input  logic       hit_wb,
  output logic [1:0] sel
);
  import hz_pkg::*;

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
// Detects a decode instruction that reads the register a load in execute fills.
module hz_load_use #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic [NSRC-1:0][REG_AW-1:0] rd_src,
  input  logic [REG_AW-1:0]           ld_dst,
  input  logic                        ld_we,
  input  logic                        ld_is_load,
  output logic                        stall_req
);
  logic [NSRC-1:0] src_hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_src_match #(.REG_AW(REG_AW)) u_cmp (
      .src    (rd_src[s]),
      .dst    (ld_dst),
      .dst_we (ld_we),
      .dst_ok (ld_is_load),
      .hit    (src_hit[s])
    );
  end

  always_comb begin
    stall_req = |src_hit;
  end
endmodule

// File: rtl/hz_flow_ctrl.sv
// Turns the stall request and the redirect into hold, flush and bubble.
module hz_flow_ctrl (
  input  logic stall_req,
  input  logic redirect,
  output logic pc_hold,
  output logic ifid_hold,
  output logic ifid_flush,
  output logic ex_bubble
);
  always_comb begin
    pc_hold    = 1'b0;
    ifid_hold  = 1'b0;
    ifid_flush = 1'b0;
    ex_bubble  = 1'b0;
    if (redirect) begin
      ifid_flush = 1'b1;
      ex_bubble  = 1'b1;
    end else if (stall_req) begin
      pc_hold    = 1'b1;
      ifid_hold  = 1'b1;
      ex_bubble  = 1'b1;
    end
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic              redirect,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ifid_flush,
  output logic              ex_bubble
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  logic [NSRC-1:0][REG_AW-1:0] id_src;
  logic [NSRC-1:0][1:0]        sel;
  logic                        stall_req;
  logic                        mem_alu_valid;

  always_comb begin
    ex_src[0]     = ex_rs1;
    ex_src[1]     = ex_rs2;
    id_src[0]     = id_rs1;
    id_src[1]     = id_rs2;
    mem_alu_valid = !mem_load;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_op
    logic hit_mem;
    logic hit_wb;

    hz_src_match #(.REG_AW(REG_AW)) u_mem (
      .src    (ex_src[s]),
      .dst    (mem_rd),
      .dst_we (mem_we),
      .dst_ok (mem_alu_valid),
      .hit    (hit_mem)
    );

    hz_src_match #(.REG_AW(REG_AW)) u_wb (
      .src    (ex_src[s]),
      .dst    (wb_rd),
      .dst_we (wb_we),
      .dst_ok (1'b1),
      .hit    (hit_wb)
    );

    hz_fwd_pick u_pick (
      .hit_mem (hit_mem),
      .hit_wb  (hit_wb),
      .sel     (sel[s])
    );
  end

  hz_load_use #(.REG_AW(REG_AW), .NSRC(NSRC)) u_lu (
    .rd_src     (id_src),
    .ld_dst     (ex_rd),
    .ld_we      (ex_we),
    .ld_is_load (ex_load),
    .stall_req  (stall_req)
  );

  hz_flow_ctrl u_flow (
    .stall_req  (stall_req),
    .redirect   (redirect),
    .pc_hold    (pc_hold),
    .ifid_hold  (ifid_hold),
    .ifid_flush (ifid_flush),
    .ex_bubble  (ex_bubble)
  );

  always_comb begin
    fwd_a = sel[0];
    fwd_b = sel[1];
  end
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_we,
  input logic              ex_load,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_we,
  input logic              mem_load,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_we,
  input logic              redirect,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              ifid_flush,
  input logic              ex_bubble
);
  import hz_pkg::*;

  always_comb begin
    // R2: register 0 is never forwarded
    a_r2_zero_a: assert (ex_rs1 != '0 || fwd_a == FWD_RF);
    a_r2_zero_b: assert (ex_rs2 != '0 || fwd_b == FWD_RF);
    // R3 / R7: a memory-stage select needs a write-enabled non-load match
    a_r3_mem_a: assert (fwd_a != FWD_MEM || (mem_we && !mem_load && mem_rd == ex_rs1));
    a_r3_mem_b: assert (fwd_b != FWD_MEM || (mem_we && !mem_load && mem_rd == ex_rs2));
    // R4: a writeback select needs a write-enabled match
    a_r4_wb_a: assert (fwd_a != FWD_WB || (wb_we && wb_rd == ex_rs1));
    a_r4_wb_b: assert (fwd_b != FWD_WB || (wb_we && wb_rd == ex_rs2));
    // R5: writeback is chosen only when the memory stage cannot supply
    a_r5_prio_a: assert (fwd_a != FWD_WB || !(mem_we && !mem_load && mem_rd == ex_rs1));
    a_r5_prio_b: assert (fwd_b != FWD_WB || !(mem_we && !mem_load && mem_rd == ex_rs2));
    // R1: code 2'b11 is never produced
    a_r1_enc: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    // R8: a hold always comes as a full interlock from a load in execute
    a_r8_hold: assert (!pc_hold || (ifid_hold && ex_bubble && !ifid_flush && ex_load && ex_we));
    // R10 / R11: a redirect flushes and never holds
    a_r10_flush: assert (!redirect || (ifid_flush && ex_bubble && !pc_hold && !ifid_hold));
    // R9: no hold without a load in execute
    a_r9_noload: assert (ex_load || !ifid_hold);
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .id_rs1     (id_rs1),
  .id_rs2     (id_rs2),
  .ex_rs1     (ex_rs1),
  .ex_rs2     (ex_rs2),
  .ex_rd      (ex_rd),
  .ex_we      (ex_we),
  .ex_load    (ex_load),
  .mem_rd     (mem_rd),
  .mem_we     (mem_we),
  .mem_load   (mem_load),
  .wb_rd      (wb_rd),
  .wb_we      (wb_we),
  .redirect   (redirect),
  .fwd_a      (fwd_a),
  .fwd_b      (fwd_b),
  .pc_hold    (pc_hold),
  .ifid_hold  (ifid_hold),
  .ifid_flush (ifid_flush),
  .ex_bubble  (ex_bubble)
);

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_we, ex_load, mem_we, mem_load, wb_we, redirect;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_hold, ifid_hold, ifid_flush, ex_bubble;

  fwd_hazard_unit #(.REG_AW(AW)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_we(wb_we), .redirect(redirect),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_flush(ifid_flush), .ex_bubble(ex_bubble)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic [AW-1:0] i1, i2, x1, x2, xrd;
    logic          xwe, xld;
    logic [AW-1:0] mrd;
    logic          mwe, mld;
    logic [AW-1:0] wrd;
    logic          wwe, br;
    logic [1:0]    ea, eb;
    logic          eph, eih, efl, ebu;
  } vec_t;

  localparam int NV = 19;
  //  req  i1 i2 x1 x2 xrd xwe xld mrd mwe mld wrd wwe br   ea  eb  ph ih fl bu
  localparam vec_t VT [NV] = '{
    '{4'd1, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 1'b0,1'b0, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R1
    '{4'd3, 5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b1,1'b0, 5'd3,1'b1,1'b0, 5'd7,1'b0,1'b0, 2'b01,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R3
    '{4'd3, 5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b1,1'b0, 5'd4,1'b1,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b01, 1'b0,1'b0,1'b0,1'b0}, // R3
    '{4'd4, 5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b0,1'b0, 5'd9,1'b1,1'b0, 5'd3,1'b1,1'b0, 2'b10,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R4
    '{4'd5, 5'd10,5'd11,5'd3, 5'd3, 5'd12,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd3,1'b1,1'b0, 2'b01,2'b01, 1'b0,1'b0,1'b0,1'b0}, // R5
    '{4'd12,5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 2'b01,2'b10, 1'b0,1'b0,1'b0,1'b0}, // R12
    '{4'd12,5'd10,5'd11,5'd4, 5'd3, 5'd12,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 2'b10,2'b01, 1'b0,1'b0,1'b0,1'b0}, // R12
    '{4'd2, 5'd10,5'd11,5'd0, 5'd0, 5'd12,1'b0,1'b0, 5'd0,1'b1,1'b0, 5'd0,1'b1,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R2
    '{4'd6, 5'd10,5'd11,5'd3, 5'd3, 5'd12,1'b0,1'b0, 5'd3,1'b0,1'b0, 5'd3,1'b0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R6
    '{4'd6, 5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b0,1'b0, 5'd3,1'b0,1'b0, 5'd3,1'b1,1'b0, 2'b10,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R6
    '{4'd7, 5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b0,1'b0, 5'd3,1'b1,1'b1, 5'd3,1'b1,1'b0, 2'b10,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R7
    '{4'd7, 5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b0,1'b0, 5'd4,1'b1,1'b1, 5'd7,1'b1,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R7
    '{4'd8, 5'd5, 5'd11,5'd1, 5'd2, 5'd5, 1'b1,1'b1, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1}, // R8
    '{4'd8, 5'd10,5'd5, 5'd1, 5'd2, 5'd5, 1'b1,1'b1, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b00, 1'b1,1'b1,1'b0,1'b1}, // R8
    '{4'd2, 5'd0, 5'd11,5'd1, 5'd2, 5'd0, 1'b1,1'b1, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R2
    '{4'd9, 5'd5, 5'd5, 5'd1, 5'd2, 5'd5, 1'b1,1'b0, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R9
    '{4'd6, 5'd5, 5'd11,5'd1, 5'd2, 5'd5, 1'b0,1'b1, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0,1'b0}, // R6
    '{4'd10,5'd10,5'd11,5'd3, 5'd4, 5'd12,1'b1,1'b0, 5'd3,1'b1,1'b0, 5'd7,1'b0,1'b1, 2'b01,2'b00, 1'b0,1'b0,1'b1,1'b1}, // R10
    '{4'd11,5'd5, 5'd11,5'd1, 5'd2, 5'd5, 1'b1,1'b1, 5'd6,1'b0,1'b0, 5'd7,1'b0,1'b1, 2'b00,2'b00, 1'b0,1'b0,1'b1,1'b1}  // R11
  };

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic drive(input vec_t v);
    id_rs1 = v.i1;  id_rs2 = v.i2;  ex_rs1 = v.x1;  ex_rs2 = v.x2;
    ex_rd = v.xrd;  ex_we = v.xwe;  ex_load = v.xld;
    mem_rd = v.mrd; mem_we = v.mwe; mem_load = v.mld;
    wb_rd = v.wrd;  wb_we = v.wwe;  redirect = v.br;
  endtask

  task automatic check(input vec_t v, input int idx);
    logic [7:0] got, exp;
    got = {fwd_a, fwd_b, pc_hold, ifid_hold, ifid_flush, ex_bubble};
    exp = {v.ea, v.eb, v.eph, v.eih, v.efl, v.ebu};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d vec %0d: got fa/fb/ph/ih/fl/bu=%b expected %b", v.req, idx, got, exp);
    end
  endtask

  function automatic vec_t idle();
    vec_t v;
    v = '0;
    v.req = 4'd1;
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive(idle());
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1: state after reset with all inputs idle
    @(negedge clk); #1;
    check(idle(), -1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      #1;
      check(VT[i], i);
    end

    // R5 / R2 sweep: both producers name every register, memory stage wins
    for (int r = 0; r < 32; r++) begin
      vec_t v;
      v = idle();
      v.req = 4'd5;
      v.x1 = 5'(r); v.x2 = 5'(r);
      v.mrd = 5'(r); v.mwe = 1'b1;
      v.wrd = 5'(r); v.wwe = 1'b1;
      v.ea = (r == 0) ? 2'b00 : 2'b01;
      v.eb = v.ea;
      @(negedge clk); drive(v); #1; check(v, 100 + r);
    end

    // R4 / R6 sweep: memory write enable low, writeback supplies
    for (int r = 0; r < 32; r++) begin
      vec_t v;
      v = idle();
      v.req = 4'd4;
      v.x1 = 5'(r); v.x2 = 5'(31 - r);
      v.mrd = 5'(r); v.mwe = 1'b0;
      v.wrd = 5'(r); v.wwe = 1'b1;
      v.ea = (r == 0) ? 2'b00 : 2'b10;
      v.eb = ((31 - r) == r) ? v.ea : 2'b00;
      @(negedge clk); drive(v); #1; check(v, 200 + r);
    end

    // R8 sweep: load-use over every decode register via rs2
    for (int r = 0; r < 32; r++) begin
      vec_t v;
      v = idle();
      v.req = 4'd8;
      v.i1 = 5'd0; v.i2 = 5'(r);
      v.xrd = 5'(r); v.xwe = 1'b1; v.xld = 1'b1;
      v.eph = (r != 0); v.eih = (r != 0); v.ebu = (r != 0);
      @(negedge clk); drive(v); #1; check(v, 300 + r);
    end

    // R1: back to idle clears every control
    @(negedge clk); drive(idle()); #1; check(idle(), 400);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule